// File: doc/BRIEF.md
# UART Modem Line Status Capture

This block watches the four modem handshake lines of one serial channel (clear-to-send, data-set-ready, ring indicator and carrier detect). Each line arrives as an active-low pin. It passes through a multi-stage synchronizer and is inverted into an active-high status bit. The four status bits and four change flags form an 8-bit status byte that the host reads. A read clears the change flags. Any flag that is set, together with an enable input, raises a modem-status interrupt request.

A loop-back input makes the status bits come from the channel's own modem control outputs instead of the pins, so software can test the path without a cable. A change flag compares each composed status bit with its value one cycle earlier. Switching loop-back on or off is therefore reported like any other line change. The ring flag reacts only to the ring status bit rising. The other three flags react to any change.

A small state machine gives the transmitter a start permission for hardware flow control. Its states are ST_RUN (starting characters is allowed), ST_DRAIN (halt requested, the current character is still being sent) and ST_HOLD (halted and idle). Its transitions are: RUN to DRAIN on halt while busy; RUN to HOLD on halt while idle; DRAIN to HOLD when the character ends; DRAIN to RUN and HOLD to RUN when the halt is withdrawn.

Top module: `uart_msr_unit`

## Requirements
- R1: Outside loop-back, status byte bits 7, 6, 5 and 4 equal the inverse of modem_n[3] (carrier), modem_n[2] (ring), modem_n[1] (data-set-ready) and modem_n[0] (clear-to-send). They follow a pin change after two clock edges.
- R2: In loop-back, bits 7, 6, 5 and 4 equal mcr_out[3], mcr_out[2], mcr_out[1] and mcr_out[0] in the same cycle, and the pins have no effect.
- R3: Change flags bit 3 (carrier), bit 1 (data-set-ready) and bit 0 (clear-to-send) set on any change of their status bit, one clock edge after that change.
- R4: Bit 2 (ring change) sets only when ring status goes from 0 to 1; a 1-to-0 change leaves it clear.
- R5: A cycle with msr_rd high clears all change flags at its closing clock edge. A flag that is set, with no read, stays set.
- R6: A change detected in the same cycle as a read leaves its flag set after that edge, while the other flags clear.
- R7: Entering or leaving loop-back sets the flag of every status bit whose value changes as a result.
- R8: msi_irq is high exactly when msi_en is high and at least one change flag is set, so it drops after a clearing read.
- R9: With fc_en high and clear-to-send status 0, tx_start_ok is low from the next edge on. If tx_busy is high the gate waits in ST_DRAIN with fc_halted low, then moves to ST_HOLD with fc_halted high one edge after tx_busy falls. It returns to ST_RUN one edge after clear-to-send status returns to 1.
- R10: With fc_en low, tx_start_ok is high whatever the clear-to-send line does.
- R11: After reset with all pins high, the status byte is 0x00, msi_irq is low, tx_start_ok is high and fc_halted is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modem_n | input | 4 | Active-low pins {carrier, ring, data-set-ready, clear-to-send} |
| loopback | input | 1 | Loop-back mode select |
| mcr_out | input | 4 | Modem control outputs {op2, op1, dtr, rts} |
| msr_rd | input | 1 | Host read strobe of the status byte, one cycle per read |
| msi_en | input | 1 | Modem-status interrupt enable |
| fc_en | input | 1 | Hardware flow control enable |
| tx_busy | input | 1 | Transmitter is shifting a character |
| msr | output | 8 | Status byte {status[3:0], change flags[3:0]} |
| msi_irq | output | 1 | Modem-status interrupt request |
| tx_start_ok | output | 1 | Transmitter may start a new character |
| fc_halted | output | 1 | Flow-control halt has fully taken effect |

## Verification
A walked vector table moves the pins one line at a time, so each flag is shown to belong to its own bit. It then drops ring status from 1 to 0 to show that the ring flag ignores falling edges. It also enters and leaves loop-back with differing control values, which separates loop-back routing from pin routing and shows that mode switches are detected. Directed tests place a line change in the same cycle as a read and toggle the interrupt enable while flags are set. They also drive clear-to-send low with the transmitter busy and then idle, which separates the drain path from the direct hold path.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int NUM_LINES = 4;
    localparam int IDX_CTS   = 0;
    localparam int IDX_DSR   = 1;
    localparam int IDX_RI    = 2;
    localparam int IDX_CD    = 3;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_HOLD  = 2'd2
    } gate_state_e;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    // Reset to the inactive (high) pin level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '1;
        end else begin
            stg[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/msr_chg_flag.sv
module msr_chg_flag #(
    parameter bit RISE_ONLY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_i,
    input  logic rd_i,
    output logic evt_o,
    output logic flag_o
);
    logic prev_q;

    generate
        if (RISE_ONLY) begin : g_rise
            assign evt_o = stat_i & ~prev_q;
        end else begin : g_any
            assign evt_o = stat_i ^ prev_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            flag_o <= 1'b0;
        end else begin
            prev_q <= stat_i;
            flag_o <= evt_o | (flag_o & ~rd_i);
        end
    end

    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !rd_i) |=> flag_o);

    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && (stat_i == prev_q)) |=> !flag_o);

    p_same_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && stat_i && !prev_q) |=> flag_o);

    generate
        if (RISE_ONLY) begin : g_chk_rise
            p_ri_fall_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (!stat_i && prev_q && !flag_o) |=> !flag_o);
        end else begin : g_chk_any
            p_any_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (stat_i != prev_q) |=> flag_o);
        end
    endgenerate
endmodule

// File: rtl/msr_txgate.sv
module msr_txgate
    import msr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fc_en_i,
    input  logic cts_i,
    input  logic tx_busy_i,
    output logic tx_start_ok_o,
    output logic fc_halted_o
);
    gate_state_e state_q, state_d;
    logic        halt;

    assign halt = fc_en_i & ~cts_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (halt) state_d = tx_busy_i ? ST_DRAIN : ST_HOLD;
            end
            ST_DRAIN: begin
                if (!halt)           state_d = ST_RUN;
                else if (!tx_busy_i) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!halt) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        tx_start_ok_o = 1'b0;
        fc_halted_o   = 1'b0;
        unique case (state_q)
            ST_RUN:   tx_start_ok_o = 1'b1;
            ST_DRAIN: ;
            ST_HOLD:  fc_halted_o   = 1'b1;
            default:  ;
        endcase
    end

    p_halt_blocks_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !tx_start_ok_o);

    p_drain_to_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && halt && !tx_busy_i) |=> fc_halted_o);

    p_no_flow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en_i |=> tx_start_ok_o);
endmodule

// File: rtl/uart_msr_unit.sv
module uart_msr_unit
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] modem_n,
    input  logic       loopback,
    input  logic [3:0] mcr_out,
    input  logic       msr_rd,
    input  logic       msi_en,
    input  logic       fc_en,
    input  logic       tx_busy,
    output logic [7:0] msr,
    output logic       msi_irq,
    output logic       tx_start_ok,
    output logic       fc_halted
);
    logic [NUM_LINES-1:0] pin_sync;
    logic [NUM_LINES-1:0] stat;
    logic [NUM_LINES-1:0] evt;
    logic [NUM_LINES-1:0] flags;

    msr_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (modem_n),
        .q_o   (pin_sync)
    );

    // Loop-back bypasses the synchronizer: control outputs are already local.
    assign stat = loopback ? mcr_out : ~pin_sync;

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            msr_chg_flag #(.RISE_ONLY(i == IDX_RI)) u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .stat_i (stat[i]),
                .rd_i   (msr_rd),
                .evt_o  (evt[i]),
                .flag_o (flags[i])
            );
        end
    endgenerate

    assign msr     = {stat, flags};
    assign msi_irq = msi_en & (|flags);

    msr_txgate u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .fc_en_i       (fc_en),
        .cts_i         (stat[IDX_CTS]),
        .tx_busy_i     (tx_busy),
        .tx_start_ok_o (tx_start_ok),
        .fc_halted_o   (fc_halted)
    );

    p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && !(|evt)) |=> !msi_irq);

    p_loop_pins_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (loopback && $past(loopback) && $stable(mcr_out)) |-> $stable(msr[7:4]));
endmodule

// File: tb/uart_msr_unit_tb_top.sv
module uart_msr_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // {loopback, mcr_out[3:0], modem_n[3:0], expected msr[7:0]}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 4'h0, 4'hE, 8'h11},  // R1 R3 cts
        {1'b0, 4'h0, 4'hC, 8'h32},  // R1 R3 dsr
        {1'b0, 4'h0, 4'h8, 8'h74},  // R1 R4 ring rise
        {1'b0, 4'h0, 4'h0, 8'hF8},  // R1 R3 carrier
        {1'b0, 4'h0, 4'h4, 8'hB0},  // R4 ring fall ignored
        {1'b0, 4'h0, 4'h5, 8'hA1},  // R3 cts fall
        {1'b0, 4'h0, 4'hF, 8'h0A},  // R3 carrier and dsr fall
        {1'b1, 4'h5, 4'hF, 8'h55},  // R2 R7 enter loop-back
        {1'b1, 4'hA, 4'h0, 8'hAB},  // R2 control change, pins moved too
        {1'b1, 4'hA, 4'hF, 8'hA0},  // R2 pins only: no effect
        {1'b0, 4'hA, 4'hA, 8'h5F},  // R7 leave loop-back
        {1'b0, 4'hA, 4'h0, 8'hFA}   // R1 R3
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] modem_n = 4'hF;
    logic       loopback = 1'b0;
    logic [3:0] mcr_out = 4'h0;
    logic       msr_rd = 1'b0;
    logic       msi_en = 1'b1;
    logic       fc_en = 1'b0;
    logic       tx_busy = 1'b0;
    logic [7:0] msr;
    logic       msi_irq, tx_start_ok, fc_halted;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_msr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .modem_n(modem_n), .loopback(loopback),
        .mcr_out(mcr_out), .msr_rd(msr_rd), .msi_en(msi_en), .fc_en(fc_en),
        .tx_busy(tx_busy), .msr(msr), .msi_irq(msi_irq),
        .tx_start_ok(tx_start_ok), .fc_halted(fc_halted)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_read();
        @(negedge clk) msr_rd = 1'b1;
        @(negedge clk) msr_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(3);
        // R11 reset state
        check("R11 msr", msr, 8'h00);
        check("R11 irq", {7'd0, msi_irq}, 8'd0);
        check("R11 start", {7'd0, tx_start_ok}, 8'd1);
        check("R11 halted", {7'd0, fc_halted}, 8'd0);

        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            loopback = VEC[v][16];
            mcr_out  = VEC[v][15:12];
            modem_n  = VEC[v][11:8];
            edges(3);
            check($sformatf("R1 R2 R3 R4 R7 vector %0d msr", v), msr, VEC[v][7:0]);
            check($sformatf("R8 vector %0d irq", v), {7'd0, msi_irq},
                  {7'd0, |VEC[v][3:0]});
            do_read();
            #1;
            check($sformatf("R5 vector %0d flags after read", v), {4'd0, msr[3:0]}, 8'd0);
            check($sformatf("R8 vector %0d irq after read", v), {7'd0, msi_irq}, 8'd0);
        end

        // R6 change in the read cycle
        @(negedge clk) begin loopback = 1'b1; mcr_out = 4'h2; end
        edges(2);
        do_read();
        @(negedge clk) mcr_out = 4'h0;
        edges(1);
        check("R3 dsr set in loop-back", msr, 8'h02);
        @(negedge clk) begin mcr_out = 4'h1; msr_rd = 1'b1; end
        edges(1);
        check("R6 same-cycle change survives read", msr, 8'h11);
        @(negedge clk) msr_rd = 1'b0;

        // R8 enable gating
        msi_en = 1'b0;
        #1;
        check("R8 irq masked", {7'd0, msi_irq}, 8'd0);
        msi_en = 1'b1;
        #1;
        check("R8 irq enabled", {7'd0, msi_irq}, 8'd1);
        do_read();
        #1;
        check("R8 irq after read", {7'd0, msi_irq}, 8'd0);

        // R10 flow control disabled, clear-to-send inactive
        @(negedge clk) begin loopback = 1'b0; modem_n = 4'hF; fc_en = 1'b0; end
        edges(3);
        check("R10 start with fc off", {7'd0, tx_start_ok}, 8'd1);

        // R9 drain then hold
        @(negedge clk) begin fc_en = 1'b1; tx_busy = 1'b1; end
        edges(1);
        check("R9 drain start", {7'd0, tx_start_ok}, 8'd0);
        check("R9 drain halted", {7'd0, fc_halted}, 8'd0);
        edges(2);
        check("R9 still draining", {7'd0, fc_halted}, 8'd0);
        @(negedge clk) tx_busy = 1'b0;
        edges(1);
        check("R9 hold halted", {7'd0, fc_halted}, 8'd1);
        @(negedge clk) modem_n = 4'hE;
        edges(2);
        check("R9 still held before sync", {7'd0, tx_start_ok}, 8'd0);
        edges(1);
        check("R9 resume start", {7'd0, tx_start_ok}, 8'd1);
        check("R9 resume halted", {7'd0, fc_halted}, 8'd0);
        @(negedge clk) modem_n = 4'hF;
        edges(2);
        check("R9 run until sync", {7'd0, tx_start_ok}, 8'd1);
        edges(1);
        check("R9 idle goes to hold", {7'd0, fc_halted}, 8'd1);
        check("R1 cts status low", {7'd0, msr[4]}, 8'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule